// File: doc/BRIEF.md
# Link Test Pattern Generator

This block drives three 10-bit link lanes during built-in self-test. Each clock it registers one character per lane, taken from one of four sources picked by a select input: constant zero, the normal encoded data presented by the upstream encoder, a pseudo-random bit sequence, or a rotating 80-bit programmed pattern. Every configuration field is a static input, so a control block elsewhere on the chip owns the settings and this block only produces characters.

The pseudo-random source offers four polynomials and can emit 1, 8 or 10 new bits per clock. It can also be parked in an idle width that freezes its state. The programmed pattern is eight 10-bit characters that play in order and wrap, each held for a programmable number of clocks. In both test modes all three lanes carry the same character. The normal-data path keeps each lane's own data.

Top module: `link_test_pattern_gen`

## Requirements
- R1: With select `001` each lane's output equals that lane's `norm_data` slice (lane n at bits 10n+9:10n), registered, one clock after it is presented.
- R2: With select `000`, or any select value other than `001`, `010` and `100`, every lane outputs 0 one clock later.
- R3: With select `010` and the generator enabled, all lanes carry the same pseudo-random character. The `prbs_mode` codes are 0 for x^11+x^9+1, 1 for x^15+x^14+1, 2 for x^7+x^6+1 and 3 for x^31+x^28+1. The register is seeded with all ones, each step shifts in the XOR of the two tap stages, and the first new bit of a clock lands in bit 0. PRBS7 at one bit per clock starts 0,0,0,0,0,0,1.
- R4: `prbs_width` 3 gives 10 new bits per clock. Width 1 gives 8 new bits, and output bits 9:8 are 0. Width 2 gives 1 new bit in bit 0. Width 0 outputs zero and freezes the generator, so a later nonzero width continues from the frozen state.
- R5: While `prbs_en` is 0 the pseudo-random output is zero and the generator returns to its seed, so the next enable restarts the sequence from the start.
- R6: With select `100` and `shift_en` high, the lanes play pattern characters 0,1,...,7 and then wrap to 0. Character k is `shift_pattern` bits 10k+9:10k. Play starts at character 0 on the first enabled clock.
- R7: A repeat value R on `shift_rep` holds each pattern character for R+1 clocks.
- R8: While `shift_en` is 0 the pattern output is zero and the rotation returns to character 0.
- R9: During and after reset, with every input at 0, all lane outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Output source select (one-hot, 000 = zero) |
| prbs_en | input | 1 | Pseudo-random generator enable |
| prbs_mode | input | 2 | Polynomial choice |
| prbs_width | input | 2 | Bits generated per clock |
| shift_en | input | 1 | Pattern rotation enable |
| shift_rep | input | 3 | Clocks per pattern character, minus one |
| shift_pattern | input | 80 | Eight 10-bit pattern characters |
| norm_data | input | 30 | Normal encoded characters, three lanes |
| lane_out | output | 30 | Registered output characters, three lanes |

## Verification
The assertions check on every cycle that invalid or zero selects blank the lanes, that the normal data passes with one clock of delay, and that the test sources put identical characters on all lanes. They also check that byte width keeps the top two bits clear, that the shift register never reaches the all-zero lockup, that an idle width freezes it, and that the pattern index only steps by one, only at the end of a hold window. The exact bit sequences for each polynomial and width are shown only by the bench's scenarios. So are the seed restart after a disable, the continuation after an idle period, the hold lengths for several repeat values, and the rotation restart.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;

    localparam int LFSR_W = 31;

    typedef enum logic [2:0] {
        SEL_ZERO   = 3'b000,
        SEL_NORMAL = 3'b001,
        SEL_PRBS   = 3'b010,
        SEL_SHIFT  = 3'b100
    } out_sel_e;

    typedef enum logic [1:0] {
        POLY_11 = 2'd0,
        POLY_15 = 2'd1,
        POLY_7  = 2'd2,
        POLY_31 = 2'd3
    } prbs_poly_e;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_BYTE = 2'd1,
        PW_BIT  = 2'd2,
        PW_CHAR = 2'd3
    } prbs_width_e;

endpackage

// File: rtl/ltpg_prbs.sv
module ltpg_prbs
    import ltpg_pkg::*;
#(
    parameter int CHAR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [1:0]        poly_i,
    input  logic [1:0]        width_i,
    output logic [CHAR_W-1:0] char_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } prbs_state_t;

    prbs_state_t state_d, state_q;
    logic [LFSR_W-1:0] live_mask;

    function automatic logic feedback(input logic [LFSR_W-1:0] s, input prbs_poly_e p);
        case (p)
            POLY_11: feedback = s[10] ^ s[8];
            POLY_15: feedback = s[14] ^ s[13];
            POLY_7:  feedback = s[6] ^ s[5];
            default: feedback = s[30] ^ s[27];
        endcase
    endfunction

    always_comb begin
        logic [LFSR_W-1:0] walk;
        logic [CHAR_W-1:0] bits;
        logic fb;
        int nsteps;
        walk = state_q.lfsr;
        bits = '0;
        case (prbs_width_e'(width_i))
            PW_IDLE: nsteps = 0;
            PW_BYTE: nsteps = 8;
            PW_BIT:  nsteps = 1;
            default: nsteps = CHAR_W;
        endcase
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < nsteps) begin
                fb = feedback(walk, prbs_poly_e'(poly_i));
                walk = {walk[LFSR_W-2:0], fb};
                bits[i] = fb;
            end
        end
        state_d.lfsr = en_i ? walk : '1;
        char_o       = en_i ? bits : '0;
    end

    always_comb begin
        case (prbs_poly_e'(poly_i))
            POLY_11: live_mask = LFSR_W'((1 << 11) - 1);
            POLY_15: live_mask = LFSR_W'((1 << 15) - 1);
            POLY_7:  live_mask = LFSR_W'((1 << 7) - 1);
            default: live_mask = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{lfsr: '1};
        else        state_q <= state_d;
    end

    AST_PRBS_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> ((state_q.lfsr & live_mask) != '0)); // R3

    AST_PRBS_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && width_i == 2'd0) |=> $stable(state_q.lfsr)); // R4

endmodule

// File: rtl/ltpg_shift.sv
module ltpg_shift #(
    parameter int CHAR_W  = 10,
    parameter int N_CHARS = 8,
    parameter int REP_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic [REP_W-1:0]          rep_i,
    input  logic [N_CHARS*CHAR_W-1:0] pattern_i,
    output logic [CHAR_W-1:0]         char_o
);

    localparam int IDX_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CHARS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [REP_W-1:0] cnt;
    } shift_state_t;

    shift_state_t state_d, state_q;
    logic [CHAR_W-1:0] chars [N_CHARS];

    for (genvar k = 0; k < N_CHARS; k++) begin : g_unpack
        assign chars[k] = pattern_i[k*CHAR_W +: CHAR_W];
    end

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = '0;
        end else if (state_q.cnt == rep_i) begin
            state_d.cnt = '0;
            state_d.idx = (state_q.idx == LAST_IDX) ? '0 : state_q.idx + 1'b1;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
        char_o = en_i ? chars[state_q.idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    AST_SHIFT_ADVANCE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && en_i && state_q.idx != $past(state_q.idx))
            |-> ($past(state_q.cnt) == $past(rep_i))); // R7

    AST_SHIFT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && en_i && state_q.idx != $past(state_q.idx))
            |-> (state_q.idx == (($past(state_q.idx) == LAST_IDX) ? '0 : $past(state_q.idx) + 1'b1))); // R6

endmodule

// File: rtl/link_test_pattern_gen.sv
module link_test_pattern_gen
    import ltpg_pkg::*;
#(
    parameter int LANES   = 3,
    parameter int CHAR_W  = 10,
    parameter int N_CHARS = 8,
    parameter int REP_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                sel,
    input  logic                      prbs_en,
    input  logic [1:0]                prbs_mode,
    input  logic [1:0]                prbs_width,
    input  logic                      shift_en,
    input  logic [REP_W-1:0]          shift_rep,
    input  logic [N_CHARS*CHAR_W-1:0] shift_pattern,
    input  logic [LANES*CHAR_W-1:0]   norm_data,
    output logic [LANES*CHAR_W-1:0]   lane_out
);

    localparam int BUS_W = LANES * CHAR_W;

    typedef struct packed {
        logic [BUS_W-1:0] lanes;
    } out_state_t;

    out_state_t out_d, out_q;
    logic [CHAR_W-1:0] prbs_char;
    logic [CHAR_W-1:0] shift_char;

    ltpg_prbs #(.CHAR_W(CHAR_W)) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (prbs_en),
        .poly_i  (prbs_mode),
        .width_i (prbs_width),
        .char_o  (prbs_char)
    );

    ltpg_shift #(.CHAR_W(CHAR_W), .N_CHARS(N_CHARS), .REP_W(REP_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (shift_en),
        .rep_i     (shift_rep),
        .pattern_i (shift_pattern),
        .char_o    (shift_char)
    );

    always_comb begin
        out_d.lanes = '0;
        case (out_sel_e'(sel))
            SEL_NORMAL: out_d.lanes = norm_data;
            SEL_PRBS: begin
                for (int l = 0; l < LANES; l++) out_d.lanes[l*CHAR_W +: CHAR_W] = prbs_char;
            end
            SEL_SHIFT: begin
                for (int l = 0; l < LANES; l++) out_d.lanes[l*CHAR_W +: CHAR_W] = shift_char;
            end
            default: out_d.lanes = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign lane_out = out_q.lanes;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'b001) |=> (lane_out == $past(norm_data))); // R1

    AST_BLANK_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel inside {3'b001, 3'b010, 3'b100}) |=> (lane_out == '0)); // R2

    AST_BYTE_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'b010 && prbs_width == 2'd1) |=> (lane_out[CHAR_W-1:8] == '0)); // R4

    AST_PATTERN_OFF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'b100 && !shift_en) |=> (lane_out == '0)); // R8

    for (genvar l = 1; l < LANES; l++) begin : g_lane_chk
        AST_TEST_LANES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == 3'b010 || sel == 3'b100)
                |=> (lane_out[l*CHAR_W +: CHAR_W] == lane_out[CHAR_W-1:0])); // R3
    end

endmodule

// File: tb/link_test_pattern_gen_tb.sv
`timescale 1ns/1ps
module link_test_pattern_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sel = '0;
    logic        prbs_en = 1'b0;
    logic [1:0]  prbs_mode = '0;
    logic [1:0]  prbs_width = '0;
    logic        shift_en = 1'b0;
    logic [2:0]  shift_rep = '0;
    logic [79:0] shift_pattern = '0;
    logic [29:0] norm_data = '0;
    logic [29:0] lane_out;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic [29:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    logic [30:0] m_lfsr = '1;
    int m_idx = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    link_test_pattern_gen u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .prbs_en(prbs_en),
        .prbs_mode(prbs_mode), .prbs_width(prbs_width), .shift_en(shift_en),
        .shift_rep(shift_rep), .shift_pattern(shift_pattern),
        .norm_data(norm_data), .lane_out(lane_out)
    );

    // reference model of the next registered output, from R1..R8
    function automatic logic [29:0] model_next();
        logic [9:0] pc, sc;
        int deg, tap, n;
        logic fb;
        pc = '0;
        sc = '0;
        case (prbs_mode)
            2'd0: begin deg = 11; tap = 9; end
            2'd1: begin deg = 15; tap = 14; end
            2'd2: begin deg = 7; tap = 6; end
            default: begin deg = 31; tap = 28; end
        endcase
        n = (prbs_width == 2'd0) ? 0 : (prbs_width == 2'd1) ? 8 : (prbs_width == 2'd2) ? 1 : 10;
        if (prbs_en) begin
            for (int i = 0; i < n; i++) begin
                fb = m_lfsr[deg-1] ^ m_lfsr[tap-1];
                m_lfsr = {m_lfsr[29:0], fb};
                pc[i] = fb;
            end
        end else begin
            m_lfsr = '1;
        end
        if (shift_en) begin
            sc = shift_pattern[m_idx*10 +: 10];
            if (m_cnt == int'(shift_rep)) begin
                m_cnt = 0;
                m_idx = (m_idx + 1) % 8;
            end else begin
                m_cnt++;
            end
        end else begin
            m_idx = 0;
            m_cnt = 0;
        end
        case (sel)
            3'b001:  return norm_data;
            3'b010:  return {3{pc}};
            3'b100:  return {3{sc}};
            default: return '0;
        endcase
    endfunction

    task automatic step(input string tag);
        item_t it;
        it.exp = model_next();
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic step_known(input logic [29:0] exp, input string tag);
        item_t it;
        logic [29:0] unused_exp;
        unused_exp = model_next();
        it.exp = exp;
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        item_t it;
        #1;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            n_checks++;
            if (lane_out !== it.exp) begin
                n_fail++;
                $display("FAIL %s: lane_out actual %h expected %h", it.tag, lane_out, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual 20000 cycles, expected fewer");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] prbs7_head;
        repeat (3) @(negedge clk);
        n_checks++;
        if (lane_out !== '0) begin
            n_fail++;
            $display("FAIL R9: lane_out in reset actual %h expected 0", lane_out);
        end
        rst_n = 1'b1;
        repeat (3) step("R9");

        // R1: normal data passes through per lane
        sel = 3'b001;
        for (int i = 0; i < 6; i++) begin
            norm_data = {10'(i * 53 + 1), 10'(i * 17 + 700), 10'(1023 - i * 91)};
            step("R1");
        end

        // R2: zero and invalid selects blank the lanes
        norm_data = 30'h2AAA_5555;
        prbs_en = 1'b1; prbs_width = 2'd3; shift_en = 1'b1;
        foreach (sbq[i]) begin end
        sel = 3'b000; step("R2"); step("R2");
        sel = 3'b011; step("R2"); step("R2");
        sel = 3'b101; step("R2");
        sel = 3'b110; step("R2");
        sel = 3'b111; step("R2");
        prbs_en = 1'b0; shift_en = 1'b0;
        step("R2");

        // R3: every polynomial at 10 bits per clock, from seed
        sel = 3'b010;
        for (int md = 0; md < 4; md++) begin
            prbs_en = 1'b0; step("R5");
            prbs_en = 1'b1; prbs_mode = 2'(md); prbs_width = 2'd3;
            repeat (25) step("R3");
        end

        // R3: hard-coded PRBS7 head at one bit per clock
        prbs_en = 1'b0; step("R5");
        prbs_en = 1'b1; prbs_mode = 2'd2; prbs_width = 2'd2;
        prbs7_head = 7'b1000000;
        for (int i = 0; i < 7; i++) step_known({3{9'b0, prbs7_head[i]}}, "R3");
        repeat (10) step("R4");

        // R4: byte width, then idle freeze and continuation
        prbs_en = 1'b0; step("R5");
        prbs_en = 1'b1; prbs_mode = 2'd0; prbs_width = 2'd1;
        repeat (15) step("R4");
        prbs_mode = 2'd3; prbs_width = 2'd0;
        repeat (5) step("R4");
        prbs_width = 2'd3;
        repeat (10) step("R4");

        // R5: disable gives zero, re-enable restarts from seed
        prbs_en = 1'b0;
        repeat (3) step("R5");
        prbs_en = 1'b1; prbs_mode = 2'd1; prbs_width = 2'd3;
        repeat (6) step("R5");
        prbs_en = 1'b0;

        // R6: rotation order and wrap
        for (int k = 0; k < 8; k++) shift_pattern[k*10 +: 10] = 10'(64 + k * 37 + (k << 7));
        sel = 3'b100; shift_rep = 3'd0; shift_en = 1'b1;
        repeat (20) step("R6");

        // R7: hold lengths
        shift_en = 1'b0; step("R8");
        shift_en = 1'b1; shift_rep = 3'd2;
        repeat (30) step("R7");
        shift_en = 1'b0; step("R8");
        shift_en = 1'b1; shift_rep = 3'd7;
        repeat (40) step("R7");

        // R8: disable mid-rotation, then restart at character 0
        shift_en = 1'b0; step("R8");
        shift_en = 1'b1; shift_rep = 3'd0;
        repeat (3) step("R8");
        shift_en = 1'b0;
        repeat (3) step("R8");
        shift_en = 1'b1;
        repeat (5) step("R8");

        sel = 3'b000;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule